// File: doc/BRIEF.md
# Scalar Unary-Operation Execution Unit

This unit executes the one-source class of scalar instructions. Each instruction word carries a format tag, an opcode, a source operand code and a destination operand code. The unit checks the tag. It maps the opcode to one of five operations: copy, conditional copy, bitwise complement, quad-group mask expansion and bit reversal. Each operation has a 32-bit and a 64-bit form. The unit returns a registered result together with a write strobe, a width indication and the destination code, all ready for the scalar register file. A run-time generation input chooses between two opcode numberings.

The unit owns the single-bit scalar condition flag. The register file supplies the source value and the current destination value on the same cycle as the valid strobe. The source operand code is passed straight through, so the file can look up the source operand.

A small state machine sequences each issue. It has three states. ST_IDLE means nothing was issued on the previous cycle. ST_DONE means a legal instruction was issued on the previous cycle, and its result is presented with the write strobe. ST_FAULT means a rejected instruction was issued on the previous cycle, and the illegal flag is raised. The machine takes one of three transitions from any state. With no valid strobe it goes to ST_IDLE. With a valid strobe on a legal word it goes to ST_DONE. With a valid strobe on a rejected word it goes to ST_FAULT.

Top module: `sou_unit`

## Requirements
- R1: A word whose bits 31:23 differ from 9'b101111101 is rejected: illegal is raised and no write occurs.
- R2: dst_idx presents bits 22:16 of the issued word, and src_code shows bits 7:0 of the current word combinationally.
- R3: With gen_new=0, opcodes (bits 15:8) 3 to 12 map in this order: copy 32, copy 64, conditional copy 32, conditional copy 64, complement 32, complement 64, quad mask 32, quad mask 64, reverse 32, reverse 64. Every other opcode is rejected.
- R4: With gen_new=1, the same ten operations take opcodes 0 to 9 in the same order. Every other opcode is rejected.
- R5: Copy writes the source value and leaves the condition flag unchanged.
- R6: Conditional copy writes the source value when the flag is 1, and the old destination value when it is 0. The flag is unchanged.
- R7: Complement writes the bitwise inverse of the source. The flag becomes 1 if the result is nonzero, else 0.
- R8: Quad mask sets all four bits of each aligned 4-bit group that has any bit set in the source, and clears the other groups. The flag becomes 1 if the result is nonzero, else 0.
- R9: Reverse writes the source with its bit order mirrored across the operation width. The flag is unchanged.
- R10: 32-bit forms use only source bits 31:0, drive result bits 63:32 to zero and output wide=0. 64-bit forms output wide=1.
- R11: A rejected word raises illegal for exactly one cycle, keeps wr_en low and leaves the condition flag unchanged.
- R12: Outputs appear on the clock edge that samples valid. A cycle with valid low gives wr_en=0 and illegal=0 on the next cycle. A synchronous reset clears the flag, wr_en and illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gen_new | input | 1 | Opcode numbering select: 0 older map, 1 newer map |
| valid | input | 1 | Instruction issue strobe |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Source operand value |
| old_dst | input | 64 | Current destination value |
| src_code | output | 8 | Source operand code of the current word |
| result | output | 64 | Registered result |
| wr_en | output | 1 | Destination write strobe |
| wide | output | 1 | 1: write a register pair, 0: a single register |
| dst_idx | output | 7 | Destination operand code |
| illegal | output | 1 | Rejected-instruction pulse |
| cond_flag | output | 1 | Scalar condition flag |

## Verification
All registered results (result, wr_en, wide, dst_idx, illegal and cond_flag) are due one clock edge after the edge that samples valid. src_code is combinational and is due in the same cycle. The bench changes inputs on falling edges and lets exactly one rising edge pass. It then checks the registered outputs on the next falling edge, and checks src_code before that rising edge. The pulse and idle behaviour is checked one further cycle later, after a cycle with valid low.

// File: rtl/sou_pkg.sv
package sou_pkg;
    typedef enum logic [2:0] {
        OP_MOV   = 3'd0,
        OP_CMOV  = 3'd1,
        OP_NOT   = 3'd2,
        OP_QMASK = 3'd3,
        OP_BREV  = 3'd4
    } sou_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2
    } sou_state_e;

    localparam logic [8:0] SOU_FMT_TAG   = 9'b101111101;
    localparam int         SOU_NUM_CODES = 10;
    localparam int         SOU_OLD_BASE  = 3;
endpackage

// File: rtl/sou_decode.sv
module sou_decode
    import sou_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        gen_new,
    output logic        legal,
    output sou_op_e     op,
    output logic        wide,
    output logic [6:0]  dst_code,
    output logic [7:0]  src_code
);
    logic [7:0] opc;
    logic [7:0] base;
    logic [7:0] off;

    always_comb begin
        src_code = instr[7:0];
        opc      = instr[15:8];
        dst_code = instr[22:16];
        base     = gen_new ? 8'd0 : 8'(SOU_OLD_BASE);
        // wraps high when opc < base, so the range test also rejects those
        off      = opc - base;
        legal    = (instr[31:23] == SOU_FMT_TAG) && (off < 8'(SOU_NUM_CODES));
        wide     = off[0];
        op       = sou_op_e'(off[3:1]);
    end
endmodule

// File: rtl/sou_alu.sv
module sou_alu
    import sou_pkg::*;
#(
    parameter int DW = 64,
    parameter int GW = 4
) (
    input  sou_op_e        op,
    input  logic           wide,
    input  logic [DW-1:0]  src,
    input  logic [DW-1:0]  old,
    input  logic           flag_in,
    output logic [DW-1:0]  res,
    output logic           flag_wr,
    output logic           flag_val
);
    localparam int HW = DW / 2;
    localparam int NG = DW / GW;

    logic [DW-1:0] src_eff;
    logic [DW-1:0] qmask;
    logic [DW-1:0] rev_full;
    logic [DW-1:0] rev_half;
    logic [DW-1:0] raw;

    assign src_eff = wide ? src : {{HW{1'b0}}, src[HW-1:0]};

    genvar g;
    generate
        for (g = 0; g < NG; g++) begin : g_quad
            assign qmask[g*GW +: GW] = {GW{|src_eff[g*GW +: GW]}};
        end
        for (g = 0; g < DW; g++) begin : g_rev_full
            assign rev_full[g] = src[DW-1-g];
        end
        for (g = 0; g < HW; g++) begin : g_rev_half
            assign rev_half[g] = src[HW-1-g];
        end
    endgenerate
    assign rev_half[DW-1:HW] = '0;

    always_comb begin
        case (op)
            OP_MOV:   raw = src_eff;
            OP_CMOV:  raw = flag_in ? src_eff : old;
            OP_NOT:   raw = ~src_eff;
            OP_QMASK: raw = qmask;
            OP_BREV:  raw = wide ? rev_full : rev_half;
            default:  raw = src_eff;
        endcase
        res      = wide ? raw : {{HW{1'b0}}, raw[HW-1:0]};
        flag_wr  = (op == OP_NOT) || (op == OP_QMASK);
        flag_val = |res;
    end
endmodule

// File: rtl/sou_unit.sv
module sou_unit
    import sou_pkg::*;
#(
    parameter int DW = 64,
    parameter int GW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gen_new,
    input  logic          valid,
    input  logic [31:0]   instr,
    input  logic [DW-1:0] src_val,
    input  logic [DW-1:0] old_dst,
    output logic [7:0]    src_code,
    output logic [DW-1:0] result,
    output logic          wr_en,
    output logic          wide,
    output logic [6:0]    dst_idx,
    output logic          illegal,
    output logic          cond_flag
);
    localparam int HW = DW / 2;

    logic          dec_legal;
    sou_op_e       dec_op;
    logic          dec_wide;
    logic [6:0]    dec_dst;
    logic [DW-1:0] alu_res;
    logic          alu_flag_wr;
    logic          alu_flag_val;

    sou_state_e    state;
    sou_state_e    state_nx;
    logic [DW-1:0] res_q;
    logic          wide_q;
    logic [6:0]    dst_q;
    sou_op_e       op_q;
    logic          flag_q;

    sou_decode u_dec (
        .instr    (instr),
        .gen_new  (gen_new),
        .legal    (dec_legal),
        .op       (dec_op),
        .wide     (dec_wide),
        .dst_code (dec_dst),
        .src_code (src_code)
    );

    sou_alu #(.DW(DW), .GW(GW)) u_alu (
        .op       (dec_op),
        .wide     (dec_wide),
        .src      (src_val),
        .old      (old_dst),
        .flag_in  (flag_q),
        .res      (alu_res),
        .flag_wr  (alu_flag_wr),
        .flag_val (alu_flag_val)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE, ST_FAULT:
                state_nx = !valid ? ST_IDLE : (dec_legal ? ST_DONE : ST_FAULT);
            default:
                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            wide_q <= 1'b0;
            dst_q  <= '0;
            op_q   <= OP_MOV;
            flag_q <= 1'b0;
        end else if (valid && dec_legal) begin
            res_q  <= alu_res;
            wide_q <= dec_wide;
            dst_q  <= dec_dst;
            op_q   <= dec_op;
            if (alu_flag_wr) flag_q <= alu_flag_val;
        end
    end

    always_comb begin
        wr_en     = (state == ST_DONE);
        illegal   = (state == ST_FAULT);
        result    = res_q;
        wide      = wide_q;
        dst_idx   = dst_q;
        cond_flag = flag_q;
    end

    assert_bad_tag_R1: assert property (@(posedge clk) disable iff (rst)
        (valid && instr[31:23] != SOU_FMT_TAG) |=> (illegal && !wr_en));

    assert_nz_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (op_q == OP_NOT || op_q == OP_QMASK)) |-> (cond_flag == (result != '0))); // R8 too

    assert_keep_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (op_q == OP_MOV || op_q == OP_CMOV || op_q == OP_BREV))
            |-> (cond_flag == $past(cond_flag)));

    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wide) |-> (result[DW-1:HW] == '0));

    assert_fault_flag_R11: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (cond_flag == $past(cond_flag)));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !valid |=> (!wr_en && !illegal));
endmodule

// File: tb/sim_sou_unit.sv
`timescale 1ns/1ps
module sim_sou_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gen_new = 1'b0;
    logic        valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_val = '0;
    logic [63:0] old_dst = '0;
    logic [7:0]  src_code;
    logic [63:0] result;
    logic        wr_en;
    logic        wide;
    logic [6:0]  dst_idx;
    logic        illegal;
    logic        cond_flag;

    int errs = 0;
    int checks = 0;
    bit exp_flag = 1'b0;
    bit done = 1'b0;

    localparam logic [8:0] TAG = 9'h17D;

    always #10 clk = ~clk;

    sou_unit u0 (
        .clk(clk), .rst(rst), .gen_new(gen_new), .valid(valid), .instr(instr),
        .src_val(src_val), .old_dst(old_dst), .src_code(src_code), .result(result),
        .wr_en(wr_en), .wide(wide), .dst_idx(dst_idx), .illegal(illegal),
        .cond_flag(cond_flag)
    );

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] m_brev(logic [63:0] s, bit w);
        logic [63:0] r = '0;
        int n = w ? 64 : 32;
        for (int i = 0; i < n; i++) r[n-1-i] = s[i];
        return r;
    endfunction

    function automatic logic [63:0] m_qmask(logic [63:0] s);
        logic [63:0] r = '0;
        for (int q = 0; q < 16; q++) if (s[4*q +: 4] != 4'h0) r[4*q +: 4] = 4'hF;
        return r;
    endfunction

    // called on a falling edge; returns on a falling edge
    task automatic issue(bit gen, logic [7:0] opc, logic [8:0] tag, logic [6:0] dst,
                         logic [7:0] sc, logic [63:0] s, logic [63:0] o);
        int k;
        int op;
        bit w;
        bit legal;
        logic [63:0] se, oe, r;
        string mreq, oreq;
        gen_new = gen;
        valid   = 1'b1;
        instr   = {tag, dst, opc, sc};
        src_val = s;
        old_dst = o;
        #1;
        chk(src_code == sc, "R2", {56'h0, src_code}, {56'h0, sc});
        k     = int'(opc) - (gen ? 0 : 3);
        legal = (tag == TAG) && (k >= 0) && (k < 10);
        op    = k / 2;
        w     = k[0];
        mreq  = (tag != TAG) ? "R1" : (gen ? "R4" : "R3");
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0;
        if (legal) begin
            se = w ? s : {32'h0, s[31:0]};
            oe = w ? o : {32'h0, o[31:0]};
            case (op)
                0: begin r = se;                   oreq = "R5"; end
                1: begin r = exp_flag ? se : oe;   oreq = "R6"; end
                2: begin r = ~se;                  oreq = "R7"; end
                3: begin r = m_qmask(se);          oreq = "R8"; end
                default: begin r = m_brev(s, w);   oreq = "R9"; end
            endcase
            if (!w) r[63:32] = 32'h0;
            if (op == 2 || op == 3) exp_flag = |r;
            chk(wr_en == 1'b1 && illegal == 1'b0, mreq, {62'h0, wr_en, illegal}, 64'h2);
            chk(result == r, oreq, result, r);
            chk(cond_flag == exp_flag, oreq, {63'h0, cond_flag}, {63'h0, exp_flag});
            chk(wide == w, "R10", {63'h0, wide}, {63'h0, w});
            chk(dst_idx == dst, "R2", {57'h0, dst_idx}, {57'h0, dst});
        end else begin
            chk(illegal == 1'b1, mreq, {63'h0, illegal}, 64'h1);
            chk(wr_en == 1'b0, "R11", {63'h0, wr_en}, 64'h0);
            chk(cond_flag == exp_flag, "R11", {63'h0, cond_flag}, {63'h0, exp_flag});
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        logic [63:0] pat [4];
        pat[0] = 64'h0;
        pat[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pat[2] = 64'h0123_4567_89AB_CDEF;
        pat[3] = 64'h8000_0F00_0000_0010;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(wr_en == 1'b0 && illegal == 1'b0, "R12", {62'h0, wr_en, illegal}, 64'h0);
        chk(cond_flag == 1'b0, "R12", {63'h0, cond_flag}, 64'h0);

        // R6 both flag values, R7 flag from zero and nonzero results
        issue(1'b1, 8'd5, TAG, 7'h11, 8'h01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        chk(cond_flag == 1'b0, "R7", {63'h0, cond_flag}, 64'h0);
        issue(1'b1, 8'd3, TAG, 7'h12, 8'h02, 64'hAAAA_0000_5555_1111, 64'h1234_5678_9ABC_DEF0);
        issue(1'b1, 8'd4, TAG, 7'h13, 8'h03, 64'hFFFF_FFFF_0000_0000, 64'h0);
        chk(cond_flag == 1'b1, "R7", {63'h0, cond_flag}, 64'h1);
        issue(1'b1, 8'd2, TAG, 7'h14, 8'h04, 64'hDEAD_BEEF_CAFE_F00D, 64'h1111_2222_3333_4444);

        // R11 one-cycle pulse, R12 idle cycle
        issue(1'b0, 8'd3, 9'h000, 7'h15, 8'h05, 64'h5, 64'h6);
        @(posedge clk);
        @(negedge clk);
        chk(illegal == 1'b0 && wr_en == 1'b0, "R11", {62'h0, wr_en, illegal}, 64'h0);
        issue(1'b0, 8'd3, TAG, 7'h16, 8'h06, 64'h77, 64'h0);
        @(posedge clk);
        @(negedge clk);
        chk(wr_en == 1'b0 && illegal == 1'b0, "R12", {62'h0, wr_en, illegal}, 64'h0);

        // R1 single-bit tag corruption
        for (int b = 0; b < 9; b++)
            issue(1'b1, 8'd0, TAG ^ (9'h1 << b), 7'h20, 8'h07, 64'h9, 64'h0);

        // R3 R4 full opcode sweep in both maps
        for (int gsel = 0; gsel < 2; gsel++)
            for (int opc = 0; opc < 256; opc++)
                for (int p = 0; p < 4; p++)
                    issue(gsel[0], 8'(opc), TAG, 7'(opc) ^ 7'h2A, 8'(opc + 7 * p),
                          pat[p] ^ {8'(opc), 56'h0} ^ {32'h0, 8'(opc), 24'h0},
                          ~pat[p]);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
            summary();
            $finish;
        end
    end
endmodule